// File: doc/BRIEF.md
# Debug-Aware Low-Power Clock Controller

This block holds one 32-bit debug configuration word and uses it to decide how the core and bus clocks behave in low-power modes, and which peripheral counters stop while the core sits at a breakpoint. Normally, sleep turns the bus clock off and stop turns both clocks off. A debug bit overrides this. In sleep, the bus clock can keep running from the system clock. In stop, the internal RC oscillator can be enabled and made the source of both clocks, so a debugger stays connected.

A second group of bits selects which peripheral counters freeze while the halt input is high. These are the timers, the watchdog, the CAN receive-register update and the SMBus timeout. Clock source and enable decisions are taken only when a low-power mode is entered or left, so they stay constant for the whole of a mode.

The configuration word is cleared only by power-on reset. System reset returns the clock outputs to the run state and clears the freeze outputs, but it leaves the word intact. The word also accepts writes while system reset is held. The number of timers is a parameter (1 to 24).

Top module: `lp_dbg_clkctl`

## Requirements
- R1: A write with `cfgWrEn` high and `cfgSize` = 2 (full word) stores the word at the next clock edge. The field positions are: bit 0 debug-sleep, bit 1 debug-stop, bit 2 watchdog freeze, bit 3 CAN receive freeze, bit 4 SMBus timeout freeze, and bits 8 upward one timer-freeze bit per timer. Every other bit is stored and read as zero.
- R2: A write whose `cfgSize` is not 2 leaves the word unchanged. `cfgRData` shows the word combinationally only while `cfgRdEn` is high and `cfgSize` is 2; otherwise it is zero.
- R3: `porRstN` low clears the word to zero at once, without waiting for a clock edge. `sysRstN` low leaves the word unchanged, and a full-word write made while `sysRstN` is low is still stored.
- R4: In sleep mode, `fclkEn` stays 1 and `clkSrcSel` stays 0 (system clock). `hclkEn` equals the debug-sleep bit sampled on entry to the mode.
- R5: In stop mode, `fclkEn`, `hclkEn`, `rcOscEn` and `clkSrcSel` (1 = RC oscillator) all equal the debug-stop bit sampled on entry. In run mode, both enables are 1 and the other two outputs are 0.
- R6: When `stopReq` and `sleepReq` are both high, stop mode is taken. With both low, the block is in run mode.
- R7: The mode is sampled at each clock edge, and the clock outputs change at the edge where the sampled mode differs from the previous one. A change to the word while the block is inside a mode has no effect on the clock outputs until the next mode change.
- R8: Each freeze output is 1 in the cycle after an edge at which `coreHalted` was high and its enable bit was set. It returns to 0 in the cycle after `coreHalted` is sampled low.
- R9: While `sysRstN` or `porRstN` is low, the block is in run mode (`fclkEn` = `hclkEn` = 1, `clkSrcSel` = `rcOscEn` = 0), and all freeze outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| porRstN | input | 1 | Power-on reset, active low, asynchronous |
| sysRstN | input | 1 | System reset, active low, asynchronous |
| cfgWrEn | input | 1 | Register write strobe |
| cfgRdEn | input | 1 | Register read enable |
| cfgSize | input | 2 | Access size: 0 byte, 1 half, 2 word |
| cfgWData | input | 32 | Write data |
| cfgRData | output | 32 | Read data |
| sleepReq | input | 1 | Core is in sleep mode |
| stopReq | input | 1 | Core is in stop mode |
| coreHalted | input | 1 | Core halted at a breakpoint |
| fclkEn | output | 1 | Core free-running clock enable |
| hclkEn | output | 1 | Bus clock enable |
| clkSrcSel | output | 1 | Clock source: 0 system, 1 RC oscillator |
| rcOscEn | output | 1 | Internal RC oscillator enable |
| tmrFreeze | output | NUM_TMR | Per-timer counter freeze |
| wdgFreeze | output | 1 | Watchdog counter freeze |
| canRxFreeze | output | 1 | Block CAN receive-register update |
| smbTmoFreeze | output | 1 | Block SMBus timeout counter |

## Verification
A corrupted configuration bit shows up in one of two places. It appears on `cfgRData` on the very next word read. It also appears on a clock or freeze output in the cycle after the next mode change or halted edge. A wrong mode register is different: it turns up as a clock-enable or source mismatch in the cycle after the faulty edge. A stale policy latch stays visible for the whole of the mode. Because of this, the bench compares every output against its behavioural model on every cycle, so each fault is caught within one cycle of reaching a port.

// File: rtl/lp_dbg_pkg.sv
package lp_dbg_pkg;

  typedef enum logic [1:0] {
    LP_RUN   = 2'd0,
    LP_SLEEP = 2'd1,
    LP_STOP  = 2'd2
  } lpMode_e;

  localparam int CFG_W        = 32;
  localparam int DBG_SLEEP_B  = 0;
  localparam int DBG_STOP_B   = 1;
  localparam int WDG_FRZ_B    = 2;
  localparam int CAN_FRZ_B    = 3;
  localparam int SMB_FRZ_B    = 4;
  localparam int TMR_LSB      = 8;
  localparam int FIXED_FRZ_N  = 3;
  localparam logic [1:0] SIZE_WORD = 2'd2;

  typedef struct packed {
    logic    cfgWr;
    logic    polLoad;
    lpMode_e polMode;
  } ctrlStb_t;

endpackage

// File: rtl/lp_dbg_ctrl.sv
module lp_dbg_ctrl
  import lp_dbg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic [1:0] cfgSize,
  input  logic       sleepReq,
  input  logic       stopReq,
  output ctrlStb_t   stb,
  output lpMode_e    modeQ
);

  lpMode_e nextMode;

  always_comb begin
    if (stopReq)       nextMode = LP_STOP;
    else if (sleepReq) nextMode = LP_SLEEP;
    else               nextMode = LP_RUN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= LP_RUN;
    else       modeQ <= nextMode;
  end

  always_comb begin
    stb.cfgWr   = cfgWrEn && (cfgSize == SIZE_WORD);
    stb.polLoad = (nextMode != modeQ);
    stb.polMode = nextMode;
  end

  // R6: stop wins over sleep
  a_r6_stop_priority: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> (modeQ == LP_STOP));

  // R4: sleep alone enters sleep
  a_r4_sleep_entry: assert property (@(posedge clk) disable iff (!rstN)
    (sleepReq && !stopReq) |=> (modeQ == LP_SLEEP));

  // R2: narrow accesses never raise the write strobe
  a_r2_narrow_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSize != SIZE_WORD) |-> !stb.cfgWr);

endmodule

// File: rtl/lp_dbg_dp.sv
module lp_dbg_dp
  import lp_dbg_pkg::*;
#(
  parameter int NUM_TMR = 8
) (
  input  logic               clk,
  input  logic               porRstN,
  input  logic               rstN,
  input  ctrlStb_t           stb,
  input  logic [CFG_W-1:0]   cfgWData,
  input  logic               cfgRdEn,
  input  logic [1:0]         cfgSize,
  input  logic               coreHalted,
  output logic [CFG_W-1:0]   cfgRData,
  output logic               fclkEn,
  output logic               hclkEn,
  output logic               clkSrcSel,
  output logic               rcOscEn,
  output logic [NUM_TMR-1:0] tmrFreeze,
  output logic               wdgFreeze,
  output logic               canRxFreeze,
  output logic               smbTmoFreeze
);

  localparam int FRZ_N = NUM_TMR + FIXED_FRZ_N;
  localparam logic [CFG_W-1:0] TMR_MASK = ((CFG_W'(1) << NUM_TMR) - CFG_W'(1)) << TMR_LSB;
  localparam logic [CFG_W-1:0] CFG_MASK = TMR_MASK | CFG_W'(32'h1F);

  logic [CFG_W-1:0] cfgQ;
  logic [FRZ_N-1:0] frzSrc;
  logic [FRZ_N-1:0] frzQ;

  // Configuration word: only power-on reset clears it
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)       cfgQ <= '0;
    else if (stb.cfgWr) cfgQ <= cfgWData & CFG_MASK;
  end

  assign cfgRData = (cfgRdEn && (cfgSize == SIZE_WORD)) ? cfgQ : '0;

  // Clock policy, latched only on a mode change
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fclkEn    <= 1'b1;
      hclkEn    <= 1'b1;
      clkSrcSel <= 1'b0;
      rcOscEn   <= 1'b0;
    end else if (stb.polLoad) begin
      unique case (stb.polMode)
        LP_SLEEP: begin
          fclkEn    <= 1'b1;
          hclkEn    <= cfgQ[DBG_SLEEP_B];
          clkSrcSel <= 1'b0;
          rcOscEn   <= 1'b0;
        end
        LP_STOP: begin
          fclkEn    <= cfgQ[DBG_STOP_B];
          hclkEn    <= cfgQ[DBG_STOP_B];
          clkSrcSel <= cfgQ[DBG_STOP_B];
          rcOscEn   <= cfgQ[DBG_STOP_B];
        end
        default: begin
          fclkEn    <= 1'b1;
          hclkEn    <= 1'b1;
          clkSrcSel <= 1'b0;
          rcOscEn   <= 1'b0;
        end
      endcase
    end
  end

  // Freeze outputs, one register per peripheral
  assign frzSrc = {cfgQ[TMR_LSB +: NUM_TMR], cfgQ[SMB_FRZ_B], cfgQ[CAN_FRZ_B], cfgQ[WDG_FRZ_B]};

  for (genvar i = 0; i < FRZ_N; i++) begin : g_frz
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) frzQ[i] <= 1'b0;
      else       frzQ[i] <= coreHalted & frzSrc[i];
    end
  end

  assign wdgFreeze    = frzQ[0];
  assign canRxFreeze  = frzQ[1];
  assign smbTmoFreeze = frzQ[2];
  assign tmrFreeze    = frzQ[FIXED_FRZ_N +: NUM_TMR];

  // R3: system reset alone keeps the word
  a_r3_cfg_kept_sysrst: assert property (@(posedge clk) disable iff (!porRstN)
    (!rstN && !stb.cfgWr) |=> $stable(cfgQ));

  // R7: clock source only moves on a mode change
  a_r7_sel_stable: assert property (@(posedge clk) disable iff (!rstN)
    !stb.polLoad |=> $stable(clkSrcSel));

  // R8: no freeze unless halted in the previous cycle
  a_r8_freeze_needs_halt: assert property (@(posedge clk) disable iff (!rstN)
    (|frzQ) |-> $past(coreHalted));

  // R8: freeze drops after halt falls
  a_r8_freeze_release: assert property (@(posedge clk) disable iff (!rstN)
    !coreHalted |=> (frzQ == '0));

endmodule

// File: rtl/lp_dbg_clkctl.sv
module lp_dbg_clkctl
  import lp_dbg_pkg::*;
#(
  parameter int NUM_TMR = 8
) (
  input  logic               clk,
  input  logic               porRstN,
  input  logic               sysRstN,
  input  logic               cfgWrEn,
  input  logic               cfgRdEn,
  input  logic [1:0]         cfgSize,
  input  logic [31:0]        cfgWData,
  output logic [31:0]        cfgRData,
  input  logic               sleepReq,
  input  logic               stopReq,
  input  logic               coreHalted,
  output logic               fclkEn,
  output logic               hclkEn,
  output logic               clkSrcSel,
  output logic               rcOscEn,
  output logic [NUM_TMR-1:0] tmrFreeze,
  output logic               wdgFreeze,
  output logic               canRxFreeze,
  output logic               smbTmoFreeze
);

  logic     rstN;
  ctrlStb_t stb;
  lpMode_e  modeQ;

  assign rstN = porRstN & sysRstN;

  lp_dbg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgSize  (cfgSize),
    .sleepReq (sleepReq),
    .stopReq  (stopReq),
    .stb      (stb),
    .modeQ    (modeQ)
  );

  lp_dbg_dp #(.NUM_TMR(NUM_TMR)) u_dp (
    .clk          (clk),
    .porRstN      (porRstN),
    .rstN         (rstN),
    .stb          (stb),
    .cfgWData     (cfgWData),
    .cfgRdEn      (cfgRdEn),
    .cfgSize      (cfgSize),
    .coreHalted   (coreHalted),
    .cfgRData     (cfgRData),
    .fclkEn       (fclkEn),
    .hclkEn       (hclkEn),
    .clkSrcSel    (clkSrcSel),
    .rcOscEn      (rcOscEn),
    .tmrFreeze    (tmrFreeze),
    .wdgFreeze    (wdgFreeze),
    .canRxFreeze  (canRxFreeze),
    .smbTmoFreeze (smbTmoFreeze)
  );

  // R5: bus clock never runs with the core clock gated
  a_r5_clock_pair: assert property (@(posedge clk) disable iff (!rstN)
    !fclkEn |-> !hclkEn);

  // R5: RC oscillator only in stop mode
  a_r5_rc_in_stop: assert property (@(posedge clk) disable iff (!rstN)
    rcOscEn |-> (modeQ == LP_STOP));

  // R9: run-mode policy right after reset release
  a_r9_run_after_reset: assert property (@(posedge clk) disable iff (!porRstN)
    !sysRstN |=> (fclkEn && hclkEn && !clkSrcSel && !rcOscEn) || !sysRstN);

endmodule

// File: tb/tb_lp_dbg_clkctl.sv
module tb_lp_dbg_clkctl;

  localparam int NT = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic porRstN = 1'b0, sysRstN = 1'b1;
  logic cfgWrEn = 1'b0, cfgRdEn = 1'b1;
  logic [1:0] cfgSize = 2'd2;
  logic [31:0] cfgWData = '0;
  logic [31:0] cfgRData;
  logic sleepReq = 1'b0, stopReq = 1'b0, coreHalted = 1'b0;
  logic fclkEn, hclkEn, clkSrcSel, rcOscEn;
  logic [NT-1:0] tmrFreeze;
  logic wdgFreeze, canRxFreeze, smbTmoFreeze;

  lp_dbg_clkctl #(.NUM_TMR(NT)) dut (.*);

  int checks = 0, failures = 0, cycles = 0;
  string curReq = "R9";

  // behavioural model state
  logic [31:0] mCfg;
  int          mMode;   // 0 run, 1 sleep, 2 stop
  logic        mF, mH, mSel, mRc;
  logic [NT+2:0] mFrz;  // {timers, smb, can, wdg}
  logic [31:0] mask;

  initial mask = 32'h1F | (((32'd1 << NT) - 1) << 8);

  function automatic void runPolicy();
    mF = 1; mH = 1; mSel = 0; mRc = 0;
  endfunction

  always @(posedge clk) begin
    logic [31:0] nCfg;
    int nm;
    cycles++;
    if (!porRstN) begin
      mCfg = 0; mMode = 0; runPolicy(); mFrz = '0;
    end else begin
      nCfg = mCfg;
      if (cfgWrEn && cfgSize == 2'd2) nCfg = cfgWData & mask;
      if (!sysRstN) begin
        mMode = 0; runPolicy(); mFrz = '0;
      end else begin
        nm = stopReq ? 2 : (sleepReq ? 1 : 0);
        if (nm != mMode) begin
          if (nm == 0) runPolicy();
          else if (nm == 1) begin mF = 1; mH = mCfg[0]; mSel = 0; mRc = 0; end
          else begin mF = mCfg[1]; mH = mCfg[1]; mSel = mCfg[1]; mRc = mCfg[1]; end
        end
        mMode = nm;
        mFrz = coreHalted ? {mCfg[8 +: NT], mCfg[4], mCfg[3], mCfg[2]} : '0;
      end
      mCfg = nCfg;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare();
    logic [31:0] expRd;
    expRd = (cfgRdEn && cfgSize == 2'd2) ? mCfg : 32'd0;
    chk({curReq, " clocks"}, {60'd0, fclkEn, hclkEn, clkSrcSel, rcOscEn}, {60'd0, mF, mH, mSel, mRc});
    chk({curReq, " freeze"}, 64'({tmrFreeze, smbTmoFreeze, canRxFreeze, wdgFreeze}), 64'(mFrz));
    chk({curReq, " rdata"}, 64'(cfgRData), 64'(expRd));
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic wr(logic [31:0] d, logic [1:0] sz);
    cfgWData = d; cfgSize = sz; cfgWrEn = 1'b1;
    cyc(1);
    cfgWrEn = 1'b0; cfgSize = 2'd2;
  endtask

  // watchdog
  initial begin
    wait (cycles > 20000);
    failures++;
    $display("FAIL watchdog actual=%0d expected<20000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    curReq = "R9";
    cyc(3);
    porRstN = 1'b1;
    cyc(2);

    curReq = "R1";
    wr(32'hFFFF_FFFF, 2'd2);
    cyc(1);
    chk("R1 unused bits zero", 64'(cfgRData), 64'h0000_FF1F);
    wr(32'h0000_0000, 2'd2);
    cyc(1);

    curReq = "R2";
    wr(32'h0000_0003, 2'd0);
    wr(32'h0000_0003, 2'd1);
    cyc(1);
    chk("R2 narrow write ignored", 64'(cfgRData), 64'd0);
    wr(32'h0000_0003, 2'd2);
    cfgSize = 2'd1; cyc(1);
    cfgSize = 2'd2; cfgRdEn = 1'b0; cyc(1);
    cfgRdEn = 1'b1; cyc(1);

    curReq = "R4";
    sleepReq = 1'b1; cyc(4);
    chk("R4 bus clock kept in sleep", 64'(hclkEn), 64'd1);
    sleepReq = 1'b0; cyc(2);
    wr(32'h0000_0002, 2'd2);
    sleepReq = 1'b1; cyc(4);
    chk("R4 bus clock gated in sleep", 64'(hclkEn), 64'd0);
    sleepReq = 1'b0; cyc(2);

    curReq = "R5";
    stopReq = 1'b1; cyc(4);
    chk("R5 RC source in debug stop", 64'(clkSrcSel), 64'd1);
    stopReq = 1'b0; cyc(2);
    wr(32'h0000_0001, 2'd2);
    stopReq = 1'b1; cyc(4);
    chk("R5 core clock gated in stop", 64'(fclkEn), 64'd0);
    stopReq = 1'b0; cyc(2);

    curReq = "R6";
    wr(32'h0000_0001, 2'd2);
    sleepReq = 1'b1; stopReq = 1'b1; cyc(3);
    stopReq = 1'b0; cyc(3);
    sleepReq = 1'b0; cyc(2);

    curReq = "R7";
    wr(32'h0000_0000, 2'd2);
    sleepReq = 1'b1; cyc(2);
    wr(32'h0000_0001, 2'd2);
    cyc(3);
    chk("R7 mid-mode change ignored", 64'(hclkEn), 64'd0);
    sleepReq = 1'b0; cyc(1);
    sleepReq = 1'b1; cyc(2);
    chk("R7 new policy on re-entry", 64'(hclkEn), 64'd1);
    stopReq = 1'b1; cyc(2);
    wr(32'h0000_0002, 2'd2);
    cyc(2);
    chk("R7 stop gating held", 64'(fclkEn), 64'd0);
    stopReq = 1'b0; sleepReq = 1'b0; cyc(2);

    curReq = "R8";
    wr(32'h0000_A51C, 2'd2);
    coreHalted = 1'b1; cyc(1);
    chk("R8 freeze after one edge", 64'(wdgFreeze), 64'd1);
    cyc(3);
    coreHalted = 1'b0; cyc(1);
    chk("R8 freeze released", 64'(tmrFreeze), 64'd0);
    wr(32'h0000_5A04, 2'd2);
    coreHalted = 1'b1; cyc(2);
    wr(32'h0000_FF18, 2'd2);
    cyc(2);
    coreHalted = 1'b0; cyc(2);
    for (int k = 0; k < 6; k++) begin
      coreHalted = k[0]; cyc(1);
    end
    coreHalted = 1'b0; cyc(1);

    curReq = "R9";
    wr(32'h0000_0003, 2'd2);
    stopReq = 1'b1; coreHalted = 1'b1; cyc(3);
    sysRstN = 1'b0; cyc(1);
    chk("R9 run policy in system reset", 64'({fclkEn, hclkEn, clkSrcSel, rcOscEn}), 64'hC);

    curReq = "R3";
    chk("R3 word kept in system reset", 64'(cfgRData), 64'h3);
    wr(32'h0000_0105, 2'd2);
    cyc(1);
    chk("R3 write under system reset", 64'(cfgRData), 64'h105);
    sysRstN = 1'b1; cyc(3);
    stopReq = 1'b0; coreHalted = 1'b0; cyc(2);
    #1 porRstN = 1'b0;
    #1 chk("R3 async power-on clear", 64'(cfgRData), 64'd0);
    cyc(2);
    porRstN = 1'b1;
    cyc(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule